// File: doc/BRIEF.md
# Floating-Point to Integer Converter with Fixed Saturation

This block turns one IEEE-754 value, in single or double precision, into a signed 32-bit or 64-bit integer. The operation selects how the value is rounded: to nearest with ties to even, toward zero, toward positive infinity or toward negative infinity. No global rounding mode is involved. A one-cycle start strobe captures the operand and the selects. One clock edge later the integer, the cause flags and a one-cycle done strobe appear on the outputs. They hold until the next start.

When the source is a NaN or an infinity, or when the rounded magnitude does not fit the signed destination, the block raises invalid. In that case it drives one fixed pattern, the largest positive integer of the destination width, whatever the sign of the source. Inexact reports that nonzero fraction bits were dropped. Subnormal sources are converted at their true value.

Top module: `fp2i_convert`

## Requirements
- R1: With `rnd_op` = 2'b00 the result is the source rounded to the nearest integer, and an exact tie goes to the even neighbour (2.5 gives 2, 3.5 gives 4, -2.5 gives -2).
- R2: `rnd_op` = 2'b01 rounds toward zero, 2'b10 rounds toward positive infinity and 2'b11 rounds toward negative infinity.
- R3: With `src_dbl` = 0 the source is the single-precision value in `operand[31:0]` and `operand[63:32]` is ignored. With `src_dbl` = 1 the source is the double-precision value in all 64 bits.
- R4: With `dst_long` = 0 the result is a 32-bit two's-complement integer in `result[31:0]` and `result[63:32]` reads zero. With `dst_long` = 1 the result is a 64-bit two's-complement integer.
- R5: A NaN or infinite source raises `flag_invalid`, clears `flag_inexact` and gives the saturation pattern.
- R6: A finite source whose rounded value is above the destination maximum or below its minimum raises `flag_invalid`, clears `flag_inexact` and gives the saturation pattern. This includes a carry out of rounding, for example 2147483647.5 rounded to nearest into a word.
- R7: The saturation pattern is 0x7FFFFFFF for a word and 0x7FFFFFFFFFFFFFFF for a long, whatever the sign of the source.
- R8: For a result that is not invalid, `flag_inexact` is set exactly when the source has a nonzero fraction below the integer's unit.
- R9: A zero source of either sign gives integer zero with no flag raised.
- R10: `done` is high for exactly the one cycle after each cycle in which `start` was high. `result` and the flags change only on that edge and hold their values otherwise.
- R11: `flag_overflow` is never raised. Every out-of-range case is reported through `flag_invalid`.
- R12: While `rst_n` is low, `result`, `done` and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture the operand and selects on this edge |
| src_dbl | input | 1 | 1: double-precision source, 0: single-precision source in [31:0] |
| dst_long | input | 1 | 1: 64-bit destination, 0: 32-bit destination |
| rnd_op | input | 2 | 00 nearest-even, 01 toward zero, 10 up, 11 down |
| operand | input | 64 | Floating-point source bits |
| result | output | 64 | Converted integer, or the saturation pattern |
| done | output | 1 | One-cycle strobe, result valid |
| flag_inexact | output | 1 | Dropped fraction was nonzero |
| flag_overflow | output | 1 | Overflow cause, always clear |
| flag_invalid | output | 1 | NaN, infinity or out-of-range source |

## Verification
The hardest cases to reach are at the edges of the destination range. One is a value just below the limit that rounding pushes over it. Another is the asymmetric negative limit, which must still convert. A third is an exact half-way fraction, which needs trailing mantissa bits to be zero. Uniform random bit patterns almost never produce any of these. The stimulus therefore draws exponents from a window around the integer widths and often clears the low fraction bits, which makes ties and carries common. Directed values cover exactly -2^31, 2^31, -2^63, 2^63 and 2147483647.5.

// File: rtl/fp2i_pkg.sv
package fp2i_pkg;

  localparam int SIG_W = 53;   // hidden bit + double fraction
  localparam int EXP_W = 13;   // signed unbiased exponent
  localparam int INT_W = 64;   // widest destination
  localparam int WORD_W = 32;  // narrow destination

  typedef enum logic [1:0] {
    RND_NEAR = 2'b00,
    RND_ZERO = 2'b01,
    RND_UP   = 2'b10,
    RND_DOWN = 2'b11
  } rnd_op_e;

  typedef struct packed {
    logic                    sign;
    logic                    is_zero;
    logic                    is_special;
    logic signed [EXP_W-1:0] exp;
    logic [SIG_W-1:0]        sig;
  } fp_unp_t;

endpackage

// File: rtl/fp2i_unpack.sv
module fp2i_unpack
  import fp2i_pkg::*;
(
  input  logic [INT_W-1:0] operand,
  input  logic             src_dbl,
  output fp_unp_t          unp
);

  localparam int D_EXP = 11;
  localparam int D_FRC = 52;
  localparam int S_EXP = 8;
  localparam int S_FRC = 23;
  localparam int S_PAD = SIG_W - 1 - S_FRC;
  localparam logic signed [EXP_W-1:0] D_BIAS = EXP_W'(1023);
  localparam logic signed [EXP_W-1:0] S_BIAS = EXP_W'(127);

  logic [D_EXP-1:0] d_exp;
  logic [S_EXP-1:0] s_exp;

  assign d_exp = operand[D_FRC +: D_EXP];
  assign s_exp = operand[S_FRC +: S_EXP];

  always_comb begin
    if (src_dbl) begin
      unp.sign       = operand[D_FRC+D_EXP];
      unp.is_special = &d_exp;
      unp.is_zero    = (d_exp == '0) && (operand[D_FRC-1:0] == '0);
      unp.sig        = {|d_exp, operand[D_FRC-1:0]};
      if (d_exp == '0) unp.exp = EXP_W'(1) - D_BIAS;
      else             unp.exp = $signed(EXP_W'(d_exp)) - D_BIAS;
    end else begin
      unp.sign       = operand[S_FRC+S_EXP];
      unp.is_special = &s_exp;
      unp.is_zero    = (s_exp == '0) && (operand[S_FRC-1:0] == '0);
      unp.sig        = {|s_exp, operand[S_FRC-1:0], {S_PAD{1'b0}}};
      if (s_exp == '0) unp.exp = EXP_W'(1) - S_BIAS;
      else             unp.exp = $signed(EXP_W'(s_exp)) - S_BIAS;
    end
  end

endmodule

// File: rtl/fp2i_align_round.sv
module fp2i_align_round
  import fp2i_pkg::*;
(
  input  fp_unp_t        unp,
  input  rnd_op_e        rnd_op,
  output logic [INT_W:0] mag,
  output logic           lost,
  output logic           huge
);

  // Fixed-point frame: bit UNIT_POS weighs 2^0 after the shift.
  localparam int GRS_PAD  = INT_W - (SIG_W - 1);   // hidden bit lands on round position
  localparam int FIX_W    = 2 * INT_W + 2;
  localparam int TOP_PAD  = FIX_W - SIG_W - GRS_PAD;
  localparam int UNIT_POS = INT_W + 1;
  localparam int SH_W     = $clog2(INT_W + 1) + 1;

  logic [FIX_W-1:0] fix;
  logic [SH_W-1:0]  sh;
  logic             tiny;
  logic [INT_W-1:0] ipart;
  logic             rbit;
  logic             sticky;
  logic             inc;

  always_comb begin
    huge = $signed(unp.exp) >= $signed(EXP_W'(INT_W));
    tiny = $signed(unp.exp) < $signed(-EXP_W'(1));
    if (tiny || huge) sh = '0;
    else              sh = SH_W'(unp.exp + EXP_W'(1));
    fix = {{TOP_PAD{1'b0}}, unp.sig, {GRS_PAD{1'b0}}} << sh;
    if (tiny) begin
      ipart  = '0;
      rbit   = 1'b0;
      sticky = |unp.sig;
    end else begin
      ipart  = fix[UNIT_POS +: INT_W];
      rbit   = fix[UNIT_POS-1];
      sticky = |fix[UNIT_POS-2:0];
    end
  end

  always_comb begin
    unique case (rnd_op)
      RND_NEAR: inc = rbit & (sticky | ipart[0]);
      RND_ZERO: inc = 1'b0;
      RND_UP:   inc = (rbit | sticky) & ~unp.sign;
      RND_DOWN: inc = (rbit | sticky) &  unp.sign;
      default:  inc = 1'b0;
    endcase
    mag  = {1'b0, ipart} + {{INT_W{1'b0}}, inc};
    lost = rbit | sticky;
  end

endmodule

// File: rtl/fp2i_saturate.sv
module fp2i_saturate
  import fp2i_pkg::*;
(
  input  logic             sign,
  input  logic             is_special,
  input  logic             huge,
  input  logic [INT_W:0]   mag,
  input  logic             lost,
  input  logic             dst_long,
  output logic [INT_W-1:0] res,
  output logic             invalid,
  output logic             inexact
);

  localparam logic [INT_W:0] LIM_LONG = {2'b00, {(INT_W-1){1'b1}}};
  localparam logic [INT_W:0] LIM_WORD = {{(INT_W-WORD_W+2){1'b0}}, {(WORD_W-1){1'b1}}};
  localparam logic [INT_W-1:0] SAT_LONG = LIM_LONG[INT_W-1:0];
  localparam logic [INT_W-1:0] SAT_WORD = LIM_WORD[INT_W-1:0];

  logic [INT_W:0]   lim;
  logic [INT_W-1:0] sval;
  logic             range_bad;

  always_comb begin
    lim       = (dst_long ? LIM_LONG : LIM_WORD) + {{INT_W{1'b0}}, sign};
    range_bad = huge | (mag > lim);
    invalid   = is_special | range_bad;
    inexact   = ~invalid & lost;
    sval      = sign ? (~mag[INT_W-1:0] + INT_W'(1)) : mag[INT_W-1:0];
    if (invalid)       res = dst_long ? SAT_LONG : SAT_WORD;
    else if (dst_long) res = sval;
    else               res = {{(INT_W-WORD_W){1'b0}}, sval[WORD_W-1:0]};
  end

endmodule

// File: rtl/fp2i_convert.sv
module fp2i_convert
  import fp2i_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             src_dbl,
  input  logic             dst_long,
  input  logic [1:0]       rnd_op,
  input  logic [INT_W-1:0] operand,
  output logic [INT_W-1:0] result,
  output logic             done,
  output logic             flag_inexact,
  output logic             flag_overflow,
  output logic             flag_invalid
);

  fp_unp_t          unp;
  logic [INT_W:0]   mag;
  logic             lost;
  logic             huge;
  logic [INT_W-1:0] res_c;
  logic             inv_c;
  logic             inx_c;

  logic [INT_W-1:0] res_q, res_d;
  logic             inv_q, inv_d;
  logic             inx_q, inx_d;
  logic             long_q, long_d;
  logic             done_q;

  fp2i_unpack u_unpack (
    .operand (operand),
    .src_dbl (src_dbl),
    .unp     (unp)
  );

  fp2i_align_round u_round (
    .unp    (unp),
    .rnd_op (rnd_op_e'(rnd_op)),
    .mag    (mag),
    .lost   (lost),
    .huge   (huge)
  );

  fp2i_saturate u_sat (
    .sign       (unp.sign),
    .is_special (unp.is_special),
    .huge       (huge),
    .mag        (mag),
    .lost       (lost),
    .dst_long   (dst_long),
    .res        (res_c),
    .invalid    (inv_c),
    .inexact    (inx_c)
  );

  // Next state: capture only when start is high.
  always_comb begin
    res_d  = res_q;
    inv_d  = inv_q;
    inx_d  = inx_q;
    long_d = long_q;
    if (start) begin
      res_d  = unp.is_zero ? '0 : res_c;
      inv_d  = inv_c;
      inx_d  = unp.is_zero ? 1'b0 : inx_c;
      long_d = dst_long;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      inv_q  <= 1'b0;
      inx_q  <= 1'b0;
      long_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      res_q  <= res_d;
      inv_q  <= inv_d;
      inx_q  <= inx_d;
      long_q <= long_d;
      done_q <= start;
    end
  end

  assign result        = res_q;
  assign done          = done_q;
  assign flag_inexact  = inx_q;
  assign flag_invalid  = inv_q;
  assign flag_overflow = 1'b0;

endmodule

// File: rtl/fp2i_convert_chk.sv
module fp2i_convert_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        done,
  input logic [63:0] result,
  input logic        flag_inexact,
  input logic        flag_invalid,
  input logic        long_q
);

  p_done_follows_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (done == $past(start)));

  p_hold_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(result) && $stable(flag_invalid) && $stable(flag_inexact)));

  p_sat_pattern_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && flag_invalid) |->
      (result == (long_q ? 64'h7FFF_FFFF_FFFF_FFFF : 64'h0000_0000_7FFF_FFFF)));

  p_invalid_not_inexact_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flag_invalid |-> !flag_inexact);

  p_word_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !long_q) |-> (result[63:32] == 32'h0));

endmodule

bind fp2i_convert fp2i_convert_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .done         (done),
  .result       (result),
  .flag_inexact (flag_inexact),
  .flag_invalid (flag_invalid),
  .long_q       (long_q)
);

// File: tb/fp2i_convert_tb.sv
module fp2i_convert_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N_RANDOM   = 3000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic        src_dbl;
  logic        dst_long;
  logic [1:0]  rnd_op;
  logic [63:0] operand;
  logic [63:0] result;
  logic        done;
  logic        flag_inexact;
  logic        flag_overflow;
  logic        flag_invalid;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp2i_convert u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .src_dbl       (src_dbl),
    .dst_long      (dst_long),
    .rnd_op        (rnd_op),
    .operand       (operand),
    .result        (result),
    .done          (done),
    .flag_inexact  (flag_inexact),
    .flag_overflow (flag_overflow),
    .flag_invalid  (flag_invalid)
  );

  // Reference: integer part and remainder compared against one half.
  function automatic void model(input logic [63:0] opnd, input logic dbl, input logic lng,
                                input logic [1:0] op, output logic [63:0] r,
                                output logic inv, output logic inx, output int klass);
    logic        sgn;
    int          bexp, fb, bias, e, k;
    logic [127:0] m, ival, rem, half, maxv;
    bit          big, up, special, zero;
    if (dbl) begin
      sgn = opnd[63]; bexp = int'(opnd[62:52]); fb = 52; bias = 1023;
      m = {75'b0, (bexp != 0), opnd[51:0]};
      special = (bexp == 2047);
    end else begin
      sgn = opnd[31]; bexp = int'(opnd[30:23]); fb = 23; bias = 127;
      m = {104'b0, (bexp != 0), opnd[22:0]};
      special = (bexp == 255);
    end
    zero = !special && (m == 0);
    r = 64'h0; inv = 0; inx = 0; big = 0; up = 0;
    ival = 0; rem = 0; half = 1;
    if (special) begin
      inv = 1; klass = 5;
    end else if (zero) begin
      klass = 9;
    end else begin
      e = ((bexp == 0) ? 1 : bexp) - bias;
      k = fb - e;
      if (k <= 0) begin
        if (e >= 64) big = 1;
        else ival = m << (-k);
      end else if (k > 100) begin
        rem = m; half = 128'd1 << 99;
      end else begin
        ival = m >> k;
        rem  = m & ((128'd1 << k) - 128'd1);
        half = 128'd1 << (k - 1);
      end
      case (op)
        2'b00: up = (rem > half) || (rem == half && ival[0]);
        2'b01: up = 0;
        2'b10: up = (rem != 0) && !sgn;
        default: up = (rem != 0) && sgn;
      endcase
      ival = ival + (up ? 128'd1 : 128'd0);
      maxv = (lng ? ((128'd1 << 63) - 1) : ((128'd1 << 31) - 1)) + (sgn ? 128'd1 : 128'd0);
      if (big || ival > maxv) begin
        inv = 1; klass = 6;
      end else begin
        inx = (rem != 0);
        klass = (op == 2'b00) ? 1 : 2;
        ival = sgn ? (~ival + 128'd1) : ival;
        r = lng ? ival[63:0] : {32'h0, ival[31:0]};
      end
    end
    if (inv) r = lng ? 64'h7FFF_FFFF_FFFF_FFFF : 64'h0000_0000_7FFF_FFFF;
  endfunction

  function automatic string tag_of(input int klass, input logic inx);
    case (klass)
      1: return inx ? "R1/R8" : "R1";
      2: return inx ? "R2/R8" : "R2";
      5: return "R5/R7";
      6: return "R6/R7";
      9: return "R9";
      default: return "R3/R4";
    endcase
  endfunction

  task automatic apply(input logic [63:0] opnd, input logic dbl, input logic lng,
                       input logic [1:0] op);
    logic [63:0] er;
    logic        ei, ex;
    int          kl;
    @(negedge clk);
    operand = opnd; src_dbl = dbl; dst_long = lng; rnd_op = op; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    model(opnd, dbl, lng, op, er, ei, ex, kl);
    n_checks++;
    if (done !== 1'b1 || result !== er || flag_invalid !== ei || flag_inexact !== ex
        || flag_overflow !== 1'b0) begin
      n_fails++;
      $display("FAIL %s (R10/R11) op=%h dbl=%0d long=%0d rnd=%0d: got res=%h inv=%0d inx=%0d ovf=%0d done=%0d, exp res=%h inv=%0d inx=%0d ovf=0 done=1",
               tag_of(kl, ex), opnd, dbl, lng, op, result, flag_invalid, flag_inexact,
               flag_overflow, done, er, ei, ex);
    end
  endtask

  // R10: new inputs without start leave the outputs untouched, done low.
  task automatic idle_check();
    logic [63:0] r0;
    logic        i0, x0;
    r0 = result; i0 = flag_invalid; x0 = flag_inexact;
    @(negedge clk);
    operand = {$urandom, $urandom}; src_dbl = ~src_dbl; dst_long = ~dst_long;
    rnd_op = rnd_op + 2'd1; start = 1'b0;
    @(negedge clk);
    n_checks++;
    if (done !== 1'b0 || result !== r0 || flag_invalid !== i0 || flag_inexact !== x0) begin
      n_fails++;
      $display("FAIL R10 hold: got res=%h inv=%0d inx=%0d done=%0d, exp res=%h inv=%0d inx=%0d done=0",
               result, flag_invalid, flag_inexact, done, r0, i0, x0);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  endtask

  function automatic logic [63:0] rand_operand(input logic dbl);
    int          c, ex;
    logic [63:0] v;
    logic [51:0] f;
    c = int'($urandom % 16);
    f = {$urandom, $urandom}[51:0];
    if (c < 6) f = f & ~((52'd1 << ($urandom % 52)) - 52'd1);   // favour ties and exact values
    if (dbl) begin
      case (c)
        0: ex = 2047;
        1: begin ex = 0; f = '0; end
        2: ex = 0;
        default: ex = 1023 + int'($urandom % 70) - 4;
      endcase
      v = {$urandom[0], 11'(ex), f};
      if (c == 3) v = {$urandom, $urandom};
    end else begin
      case (c)
        0: ex = 255;
        1: begin ex = 0; f = '0; end
        2: ex = 0;
        default: ex = 127 + int'($urandom % 70) - 4;
      endcase
      v = {$urandom, $urandom[0], 8'(ex), f[51:29]};   // R3: random upper half
      if (c == 3) v = {$urandom, $urandom};
    end
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog: got no completion, exp completion within 200000 cycles");
    report();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start = 1'b0; src_dbl = 1'b0; dst_long = 1'b0; rnd_op = 2'b00; operand = '0;
    repeat (3) @(negedge clk);
    n_checks++;   // R12
    if (result !== 64'h0 || done !== 1'b0 || flag_invalid !== 1'b0 || flag_inexact !== 1'b0
        || flag_overflow !== 1'b0) begin
      n_fails++;
      $display("FAIL R12 reset: got res=%h done=%0d inv=%0d inx=%0d ovf=%0d, exp all zero",
               result, done, flag_invalid, flag_inexact, flag_overflow);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R1 ties
    apply(64'h4004_0000_0000_0000, 1, 0, 2'b00);   // 2.5 -> 2
    apply(64'h400C_0000_0000_0000, 1, 0, 2'b00);   // 3.5 -> 4
    apply(64'hC004_0000_0000_0000, 1, 1, 2'b00);   // -2.5 -> -2
    apply(64'h3FE0_0000_0000_0000, 1, 0, 2'b00);   // 0.5 -> 0
    apply(64'h3FF8_0000_0000_0000, 1, 1, 2'b00);   // 1.5 -> 2
    // R2 directions
    apply(64'h3FB9_9999_9999_999A, 1, 0, 2'b10);   // 0.1 up -> 1
    apply(64'hBFB9_9999_9999_999A, 1, 0, 2'b11);   // -0.1 down -> -1
    apply(64'hBFB9_9999_9999_999A, 1, 1, 2'b01);   // -0.1 toward zero -> 0
    apply(64'hFFFF_FFFF_BFC0_0000, 0, 0, 2'b01);   // R3 single -1.5 with junk upper
    // R9 zeros
    apply(64'h8000_0000_0000_0000, 1, 1, 2'b10);
    apply(64'h1234_5678_8000_0000, 0, 0, 2'b11);
    // R5 specials
    apply(64'h7FF0_0000_0000_0000, 1, 0, 2'b00);
    apply(64'h7FF8_0000_0000_0000, 1, 1, 2'b01);
    apply(64'h0000_0000_FF80_0000, 0, 1, 2'b10);
    // R6 range edges
    apply(64'h41E0_0000_0000_0000, 1, 0, 2'b01);   // 2^31 word -> invalid
    apply(64'hC1E0_0000_0000_0000, 1, 0, 2'b01);   // -2^31 word -> valid
    apply(64'h43E0_0000_0000_0000, 1, 1, 2'b00);   // 2^63 long -> invalid
    apply(64'hC3E0_0000_0000_0000, 1, 1, 2'b00);   // -2^63 long -> valid
    apply(64'h41DF_FFFF_FFE0_0000, 1, 0, 2'b00);   // 2147483647.5 nearest -> carry out
    apply(64'h41DF_FFFF_FFE0_0000, 1, 0, 2'b01);   // same, toward zero -> fits
    apply(64'h0000_0000_4F00_0000, 0, 0, 2'b00);   // single 2^31 word -> invalid
    apply(64'h0000_0000_0000_0001, 0, 1, 2'b10);   // smallest subnormal up -> 1
    idle_check();

    for (int i = 0; i < N_RANDOM; i++) begin
      logic d;
      d = $urandom[0];
      apply(rand_operand(d), d, $urandom[0], 2'($urandom));
      if (i % 8 == 7) idle_check();
    end
    report();
  end

endmodule